// File: doc/BRIEF.md
# Channel Buffer Status Tracker

This block follows the buffer-by-buffer progress of one logical channel on a serial media bus whose payload is moved by DMA. Software arms the next buffer by pulsing a ready request. The DMA side reports strobes for the first and the last 32-bit quadlet of each buffer. The channel side presents each command byte (receive direction) or receiver status byte (transmit direction) it observes. From these inputs the block holds a ready flag and collects per-buffer status. It places that status in one of two four-bit groups, "previous buffer" or "current buffer", and drives a maskable and a non-maskable interrupt.

A two-state sequencer does the tracking. State `ST_IDLE` means no buffer is in flight. State `ST_XFER` means an armed buffer has moved its first quadlet but not yet its last. There are three transitions. *Launch* (`ST_IDLE` to `ST_XFER`) happens on a first-quadlet strobe while ready is set. *Finish* (`ST_XFER` to `ST_IDLE`) happens on a last-quadlet strobe. *Flash* (`ST_IDLE` to `ST_IDLE`) is a single-quadlet buffer, where launch and last quadlet fall in the same cycle. All status of a buffer is committed in its finishing cycle. If ready is armed at that moment, the status goes to the previous group and the current group is left alone. Otherwise it goes to the current group.

Within each group, bit 0 is start, bit 1 is done, bit 2 is break and bit 3 is protocol error. Two more sticky bits sit outside the groups: lost frame sync and host bus fault.

Top module: `chbuf_status_tracker`

## Requirements
- R1: While reset is active and directly after it, ready, both groups, lost-sync, bus fault and both interrupts are all 0.
- R2: A `rdy_set` pulse sets ready and a `rdy_clr` pulse clears it. When both pulse in the same cycle, set wins.
- R3: With `ping_pong`=1, a launch clears ready in the same edge unless `rdy_set` pulses in that cycle. With `ping_pong`=0, hardware never clears ready.
- R4: A first-quadlet strobe while ready is 0, or while a buffer is already in flight, has no effect. A last-quadlet strobe with no buffer in flight has no effect.
- R5: At finish, the buffer's status is ORed into the previous group (bits [3:0] = perr, break, done, start) if ready is set and was not consumed by this cycle's launch. In that case the current group does not change. Otherwise the status goes into the current group, and the previous group does not change.
- R6: A committed status always has done (bit 1) and start (bit 0) set. Break and protocol error seen during the buffer, from launch cycle to finish cycle inclusive, are committed alongside them.
- R7: Transmit direction (`is_rx`=0): byte 0x70 flags break. Byte 0x72 flags protocol error only when `chan_kind` is 0 (control) or 1 (asynchronous), never for 2 (synchronous) or 3 (isochronous).
- R8: Receive direction: bytes 0x36 and 0x26 flag break for any kind. A byte outside the kind's valid set flags protocol error. Valid sets: 0x00 for all kinds; control adds 0x30, 0x32, 0x34; asynchronous adds 0x20, 0x22, 0x24; synchronous adds 0x10; isochronous adds 0x18.
- R9: Receive direction: the kind's own start code (0x30 control, 0x20 asynchronous) opens a packet. The own end code (0x34 / 0x24) or a break code closes it. An own start code while a packet is open flags protocol error.
- R10: A lost-sync strobe sets the lost-sync bit only when `chan_kind` is 2 (synchronous).
- R11: A host bus fault strobe sets the bus fault bit. `irq_nmi` equals that bit, and no enable affects it.
- R12: Every status bit is sticky until a write-one-to-clear pulse on its clear input. A set and a clear on the same bit in the same cycle leave it set.
- R13: `irq_mask` is high exactly when some status bit is set together with its enable: `irq_en`[3:0] for the previous group, [7:4] for the current group, [8] for lost-sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ping_pong | input | 1 | 1: ping-pong buffering, 0: circular buffering |
| is_rx | input | 1 | Channel direction, 1 receive, 0 transmit |
| chan_kind | input | 2 | 0 control, 1 asynchronous, 2 synchronous, 3 isochronous |
| rdy_set | input | 1 | Software pulse arming the next buffer |
| rdy_clr | input | 1 | Software pulse disarming ready |
| ev_first | input | 1 | First quadlet of a buffer moved |
| ev_last | input | 1 | Last quadlet of a buffer moved |
| byte_vld | input | 1 | `byte_val` is valid this cycle |
| byte_val | input | 8 | Observed command (receive) or receiver status (transmit) |
| lost_sync_ev | input | 1 | Frame synchronization lost strobe |
| bus_fault_ev | input | 1 | Host bus fault strobe (read for transmit, write for receive) |
| w1c_prev | input | 4 | Clear pulses for the previous group |
| w1c_cur | input | 4 | Clear pulses for the current group |
| w1c_lfs | input | 1 | Clear pulse for lost-sync |
| w1c_hbe | input | 1 | Clear pulse for bus fault |
| irq_en | input | 9 | Maskable interrupt enables |
| rdy | output | 1 | Ready flag |
| busy | output | 1 | A buffer is in flight |
| prev_stat | output | 4 | Previous group: perr, break, done, start |
| cur_stat | output | 4 | Current group: perr, break, done, start |
| lfs_stat | output | 1 | Lost-sync bit |
| hbe_stat | output | 1 | Host bus fault bit |
| irq_mask | output | 1 | Maskable interrupt |
| irq_nmi | output | 1 | Non-maskable interrupt |

## Verification
The assertions assume that every strobe and clear input is a single-cycle pulse sampled on the rising edge. They also assume that `ping_pong`, `is_rx` and `chan_kind` change only when no buffer is in flight. The stimulus moves those mode inputs only between buffers, while the sequencer is idle. Every event strobe is driven for exactly one cycle, and the w1c masks are cleared after each use.

// File: rtl/chbuf_pkg.sv
package chbuf_pkg;
    localparam int GRP_W  = 4;
    localparam int BYTE_W = 8;
    localparam int EN_W   = 2 * GRP_W + 1;
    localparam int B_START = 0;
    localparam int B_DONE  = 1;
    localparam int B_BRK   = 2;
    localparam int B_PERR  = 3;

    typedef enum logic [1:0] {
        KIND_CTRL  = 2'd0,
        KIND_ASYNC = 2'd1,
        KIND_SYNC  = 2'd2,
        KIND_ISOC  = 2'd3
    } chan_kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_XFER = 1'b1
    } seq_state_e;
endpackage

// File: rtl/chbuf_decode.sv
module chbuf_decode
    import chbuf_pkg::*;
#(
    parameter int BW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          is_rx,
    input  logic [1:0]    kind,
    input  logic          byte_vld,
    input  logic [BW-1:0] byte_val,
    output logic          brk_hit,
    output logic          perr_hit,
    output logic          pkt_active
);
    localparam logic [BW-1:0] TX_BRK    = BW'(8'h70);
    localparam logic [BW-1:0] TX_PERR   = BW'(8'h72);
    localparam logic [BW-1:0] RX_IDLE   = BW'(8'h00);
    localparam logic [BW-1:0] C_START   = BW'(8'h30);
    localparam logic [BW-1:0] C_DATA    = BW'(8'h32);
    localparam logic [BW-1:0] C_END     = BW'(8'h34);
    localparam logic [BW-1:0] C_BRK     = BW'(8'h36);
    localparam logic [BW-1:0] A_START   = BW'(8'h20);
    localparam logic [BW-1:0] A_DATA    = BW'(8'h22);
    localparam logic [BW-1:0] A_END     = BW'(8'h24);
    localparam logic [BW-1:0] A_BRK     = BW'(8'h26);
    localparam logic [BW-1:0] S_DATA    = BW'(8'h10);
    localparam logic [BW-1:0] I_DATA    = BW'(8'h18);

    chan_kind_e kind_e;
    logic       rx_brk_code;
    logic       own_start;
    logic       own_end;
    logic       code_ok;
    logic       pkt_q;
    logic       pkt_d;

    assign kind_e = chan_kind_e'(kind);

    always_comb begin
        rx_brk_code = (byte_val == C_BRK) || (byte_val == A_BRK);
        own_start   = 1'b0;
        own_end     = 1'b0;
        code_ok     = (byte_val == RX_IDLE) || rx_brk_code;
        unique case (kind_e)
            KIND_CTRL: begin
                own_start = (byte_val == C_START);
                own_end   = (byte_val == C_END);
                code_ok   = code_ok || own_start || own_end || (byte_val == C_DATA);
            end
            KIND_ASYNC: begin
                own_start = (byte_val == A_START);
                own_end   = (byte_val == A_END);
                code_ok   = code_ok || own_start || own_end || (byte_val == A_DATA);
            end
            KIND_SYNC: code_ok = code_ok || (byte_val == S_DATA);
            KIND_ISOC: code_ok = code_ok || (byte_val == I_DATA);
        endcase
    end

    always_comb begin
        brk_hit  = 1'b0;
        perr_hit = 1'b0;
        pkt_d    = pkt_q;
        if (byte_vld) begin
            if (is_rx) begin
                brk_hit  = rx_brk_code;
                perr_hit = !code_ok || (own_start && pkt_q);
                if (own_start) begin
                    pkt_d = 1'b1;
                end else if (own_end || rx_brk_code) begin
                    pkt_d = 1'b0;
                end
            end else begin
                brk_hit  = (byte_val == TX_BRK);
                perr_hit = (byte_val == TX_PERR) &&
                           (kind_e == KIND_CTRL || kind_e == KIND_ASYNC);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pkt_q <= 1'b0;
        end else begin
            pkt_q <= pkt_d;
        end
    end

    assign pkt_active = pkt_q;

    // R7
    tx_stream_no_perr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_rx && (kind_e == KIND_SYNC || kind_e == KIND_ISOC)) |-> !perr_hit);

    // R9
    pkt_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rx && byte_vld && (own_end || rx_brk_code)) |=> !pkt_active);
endmodule

// File: rtl/chbuf_seq.sv
module chbuf_seq
    import chbuf_pkg::*;
#(
    parameter int GW = GRP_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ping_pong,
    input  logic          rdy_set,
    input  logic          rdy_clr,
    input  logic          ev_first,
    input  logic          ev_last,
    input  logic          brk_hit,
    input  logic          perr_hit,
    output logic          rdy,
    output logic          busy,
    output logic          commit,
    output logic          route_prev,
    output logic [GW-1:0] commit_vec
);
    seq_state_e    state_q;
    seq_state_e    state_d;
    logic          rdy_q;
    logic [GW-1:0] pend_q;
    logic [GW-1:0] acc;
    logic          launch;
    logic          in_buf;
    logic          finish;

    always_comb begin
        launch = (state_q == ST_IDLE) && rdy_q && ev_first;
        in_buf = (state_q == ST_XFER) || launch;
        finish = in_buf && ev_last;
        acc    = pend_q;
        if (launch)               acc[B_START] = 1'b1;
        if (in_buf && brk_hit)    acc[B_BRK]   = 1'b1;
        if (in_buf && perr_hit)   acc[B_PERR]  = 1'b1;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (launch && !ev_last) state_d = ST_XFER;
            ST_XFER: if (ev_last)            state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rdy_q   <= 1'b0;
            pend_q  <= '0;
        end else begin
            state_q <= state_d;
            if (rdy_set) begin
                rdy_q <= 1'b1;
            end else if (rdy_clr || (ping_pong && launch)) begin
                rdy_q <= 1'b0;
            end
            pend_q <= (in_buf && !finish) ? acc : '0;
        end
    end

    always_comb begin
        commit             = finish;
        route_prev         = rdy_q && !(ping_pong && launch);
        commit_vec         = acc;
        commit_vec[B_DONE] = 1'b1;
        rdy                = rdy_q;
        busy               = (state_q == ST_XFER);
    end

    // R2
    rdy_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_set |=> rdy_q);

    // R3
    pingpong_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ping_pong && ev_first && !busy && rdy_q && !rdy_set) |=> !rdy_q);

    // R3
    circular_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ping_pong && rdy_q && !rdy_clr) |=> rdy_q);

    // R4
    unarmed_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !rdy_q) |=> state_q == ST_IDLE);
endmodule

// File: rtl/chbuf_status.sv
module chbuf_status
    import chbuf_pkg::*;
#(
    parameter int GW = GRP_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      kind,
    input  logic            commit,
    input  logic            route_prev,
    input  logic [GW-1:0]   commit_vec,
    input  logic            lost_sync_ev,
    input  logic            bus_fault_ev,
    input  logic [GW-1:0]   w1c_prev,
    input  logic [GW-1:0]   w1c_cur,
    input  logic            w1c_lfs,
    input  logic            w1c_hbe,
    input  logic [2*GW:0]   irq_en,
    output logic [GW-1:0]   prev_q,
    output logic [GW-1:0]   cur_q,
    output logic            lfs_q,
    output logic            hbe_q,
    output logic            irq_mask,
    output logic            irq_nmi
);
    localparam int NGRP = 2;

    logic [NGRP-1:0][GW-1:0] grp_q;
    logic [NGRP-1:0][GW-1:0] grp_clr;
    logic [NGRP-1:0]         grp_sel;
    logic                    lfs_set;

    assign grp_clr[0] = w1c_prev;
    assign grp_clr[1] = w1c_cur;
    assign grp_sel[0] = commit && route_prev;
    assign grp_sel[1] = commit && !route_prev;
    assign lfs_set    = lost_sync_ev && (chan_kind_e'(kind) == KIND_SYNC);

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                grp_q[g] <= '0;
            end else begin
                grp_q[g] <= (grp_q[g] & ~grp_clr[g]) | (grp_sel[g] ? commit_vec : '0);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lfs_q <= 1'b0;
            hbe_q <= 1'b0;
        end else begin
            lfs_q <= (lfs_q && !w1c_lfs) || lfs_set;
            hbe_q <= (hbe_q && !w1c_hbe) || bus_fault_ev;
        end
    end

    assign prev_q   = grp_q[0];
    assign cur_q    = grp_q[1];
    assign irq_mask = |(grp_q[0] & irq_en[GW-1:0]) | |(grp_q[1] & irq_en[2*GW-1:GW])
                    | (lfs_q & irq_en[2*GW]);
    assign irq_nmi  = hbe_q;

    // R5
    prev_keeps_cur_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && route_prev && w1c_cur == '0) |=> $stable(cur_q));

    // R6
    done_always_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && route_prev) |=> (prev_q[B_DONE] && prev_q[B_START]));

    // R11
    fault_nmi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_fault_ev |=> irq_nmi);

    // R12
    clear_works_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (w1c_hbe && !bus_fault_ev) |=> !hbe_q);
endmodule

// File: rtl/chbuf_status_tracker.sv
module chbuf_status_tracker
    import chbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ping_pong,
    input  logic              is_rx,
    input  logic [1:0]        chan_kind,
    input  logic              rdy_set,
    input  logic              rdy_clr,
    input  logic              ev_first,
    input  logic              ev_last,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_val,
    input  logic              lost_sync_ev,
    input  logic              bus_fault_ev,
    input  logic [GRP_W-1:0]  w1c_prev,
    input  logic [GRP_W-1:0]  w1c_cur,
    input  logic              w1c_lfs,
    input  logic              w1c_hbe,
    input  logic [EN_W-1:0]   irq_en,
    output logic              rdy,
    output logic              busy,
    output logic [GRP_W-1:0]  prev_stat,
    output logic [GRP_W-1:0]  cur_stat,
    output logic              lfs_stat,
    output logic              hbe_stat,
    output logic              irq_mask,
    output logic              irq_nmi
);
    logic             brk_hit;
    logic             perr_hit;
    logic             pkt_active;
    logic             commit;
    logic             route_prev;
    logic [GRP_W-1:0] commit_vec;

    chbuf_decode #(.BW(BYTE_W)) u_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .is_rx      (is_rx),
        .kind       (chan_kind),
        .byte_vld   (byte_vld),
        .byte_val   (byte_val),
        .brk_hit    (brk_hit),
        .perr_hit   (perr_hit),
        .pkt_active (pkt_active)
    );

    chbuf_seq #(.GW(GRP_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .ping_pong  (ping_pong),
        .rdy_set    (rdy_set),
        .rdy_clr    (rdy_clr),
        .ev_first   (ev_first),
        .ev_last    (ev_last),
        .brk_hit    (brk_hit),
        .perr_hit   (perr_hit),
        .rdy        (rdy),
        .busy       (busy),
        .commit     (commit),
        .route_prev (route_prev),
        .commit_vec (commit_vec)
    );

    chbuf_status #(.GW(GRP_W)) u_status (
        .clk          (clk),
        .rst_n        (rst_n),
        .kind         (chan_kind),
        .commit       (commit),
        .route_prev   (route_prev),
        .commit_vec   (commit_vec),
        .lost_sync_ev (lost_sync_ev),
        .bus_fault_ev (bus_fault_ev),
        .w1c_prev     (w1c_prev),
        .w1c_cur      (w1c_cur),
        .w1c_lfs      (w1c_lfs),
        .w1c_hbe      (w1c_hbe),
        .irq_en       (irq_en),
        .prev_q       (prev_stat),
        .cur_q        (cur_stat),
        .lfs_q        (lfs_stat),
        .hbe_q        (hbe_stat),
        .irq_mask     (irq_mask),
        .irq_nmi      (irq_nmi)
    );

    // R9
    pkt_idle_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_rx && !$past(is_rx) && !$past(pkt_active)) |-> !pkt_active);
endmodule

// File: tb/chbuf_status_tracker_test.sv
module chbuf_status_tracker_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ping_pong = 1'b1;
    logic       is_rx = 1'b0;
    logic [1:0] chan_kind = 2'd1;
    logic       rdy_set = 0, rdy_clr = 0, ev_first = 0, ev_last = 0;
    logic       byte_vld = 0;
    logic [7:0] byte_val = 8'h00;
    logic       lost_sync_ev = 0, bus_fault_ev = 0;
    logic [3:0] w1c_prev = 0, w1c_cur = 0;
    logic       w1c_lfs = 0, w1c_hbe = 0;
    logic [8:0] irq_en = 9'h1FF;
    logic       rdy, busy, lfs_stat, hbe_stat, irq_mask, irq_nmi;
    logic [3:0] prev_stat, cur_stat;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    string req = "R1";

    // reference model state
    bit       m_rdy, m_busy, m_lfs, m_hbe, m_pkt;
    bit [3:0] m_pend, m_prev, m_cur;
    bit [2:0] t_cls;
    bit [3:0] t_acc;
    bit       t_start, t_in, t_fin, t_prev;

    always #4 clk = ~clk;

    chbuf_status_tracker uut (
        .clk(clk), .rst_n(rst_n), .ping_pong(ping_pong), .is_rx(is_rx),
        .chan_kind(chan_kind), .rdy_set(rdy_set), .rdy_clr(rdy_clr),
        .ev_first(ev_first), .ev_last(ev_last), .byte_vld(byte_vld),
        .byte_val(byte_val), .lost_sync_ev(lost_sync_ev), .bus_fault_ev(bus_fault_ev),
        .w1c_prev(w1c_prev), .w1c_cur(w1c_cur), .w1c_lfs(w1c_lfs), .w1c_hbe(w1c_hbe),
        .irq_en(irq_en), .rdy(rdy), .busy(busy), .prev_stat(prev_stat),
        .cur_stat(cur_stat), .lfs_stat(lfs_stat), .hbe_stat(hbe_stat),
        .irq_mask(irq_mask), .irq_nmi(irq_nmi)
    );

    // returns {packet open next, protocol error, break}
    function automatic bit [2:0] classify(bit rx, int kind, bit vld, int b, bit pkt);
        bit brk, perr, ok, st, en;
        if (!vld) return {pkt, 2'b00};
        if (!rx) begin
            brk  = (b == 'h70);
            perr = (b == 'h72) && (kind < 2);
            return {pkt, perr, brk};
        end
        brk = (b == 'h36) || (b == 'h26);
        st  = (kind == 0 && b == 'h30) || (kind == 1 && b == 'h20);
        en  = (kind == 0 && b == 'h34) || (kind == 1 && b == 'h24);
        ok  = (b == 0) || brk || st || en || (kind == 0 && b == 'h32) ||
              (kind == 1 && b == 'h22) || (kind == 2 && b == 'h10) || (kind == 3 && b == 'h18);
        perr = !ok || (st && pkt);
        if (st) pkt = 1;
        else if (en || brk) pkt = 0;
        return {pkt, perr, brk};
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_rdy = 0; m_busy = 0; m_lfs = 0; m_hbe = 0; m_pkt = 0;
            m_pend = 0; m_prev = 0; m_cur = 0;
        end else begin
            t_cls   = classify(is_rx, int'(chan_kind), byte_vld, int'(byte_val), m_pkt);
            t_start = !m_busy && m_rdy && ev_first;
            t_in    = m_busy || t_start;
            t_acc   = m_pend;
            if (t_start) t_acc[0] = 1;
            if (t_in && t_cls[0]) t_acc[2] = 1;
            if (t_in && t_cls[1]) t_acc[3] = 1;
            t_fin   = t_in && ev_last;
            t_prev  = m_rdy && !(ping_pong && t_start);
            m_prev  = (m_prev & ~w1c_prev) | ((t_fin && t_prev) ? (t_acc | 4'b0010) : 4'b0);
            m_cur   = (m_cur & ~w1c_cur) | ((t_fin && !t_prev) ? (t_acc | 4'b0010) : 4'b0);
            m_lfs   = (m_lfs && !w1c_lfs) || (lost_sync_ev && chan_kind == 2);
            m_hbe   = (m_hbe && !w1c_hbe) || bus_fault_ev;
            m_pkt   = is_rx ? t_cls[2] : m_pkt;
            if (rdy_set) m_rdy = 1;
            else if (rdy_clr || (ping_pong && t_start)) m_rdy = 0;
            m_busy  = t_fin ? 0 : (t_start ? 1 : m_busy);
            m_pend  = (t_in && !t_fin) ? t_acc : 4'b0;
        end
    end

    task automatic check_all();
        bit [13:0] act, exp;
        bit em;
        em  = |(m_prev & irq_en[3:0]) || |(m_cur & irq_en[7:4]) || (m_lfs && irq_en[8]);
        act = {rdy, busy, prev_stat, cur_stat, lfs_stat, hbe_stat, irq_mask, irq_nmi};
        exp = {m_rdy, m_busy, m_prev, m_cur, m_lfs, m_hbe, em, m_hbe};
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: rdy/busy/prev/cur/lfs/hbe/irqm/nmi actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
        check_all();
        rdy_set = 0; rdy_clr = 0; ev_first = 0; ev_last = 0; byte_vld = 0;
        lost_sync_ev = 0; bus_fault_ev = 0; w1c_prev = 0; w1c_cur = 0;
        w1c_lfs = 0; w1c_hbe = 0;
    endtask

    task automatic put_byte(input logic [7:0] b);
        byte_vld = 1; byte_val = b; tick();
    endtask

    task automatic wipe();
        w1c_prev = 4'hF; w1c_cur = 4'hF; w1c_lfs = 1; w1c_hbe = 1; tick();
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        req = "R1";
        tick(); tick();
        rst_n = 1;
        tick();
        // R2 set, clear, both
        req = "R2";
        rdy_set = 1; tick();
        rdy_clr = 1; tick();
        rdy_set = 1; rdy_clr = 1; tick();
        rdy_clr = 1; tick();
        // R4 first quadlet with ready low, last with nothing in flight
        req = "R4";
        ev_first = 1; tick();
        ev_last = 1; tick();
        // R3 R5 ping-pong, no re-arm -> current group
        req = "R3";
        rdy_set = 1; tick();
        ev_first = 1; tick();
        req = "R4";
        ev_first = 1; tick();
        req = "R5";
        ev_last = 1; tick(); tick();
        // R5 re-armed mid-buffer -> previous group
        rdy_set = 1; tick();
        ev_first = 1; tick();
        rdy_set = 1; tick();
        ev_last = 1; tick();
        wipe();
        // R7 R6 TX async break and protocol error
        req = "R7";
        ev_first = 1; tick();
        put_byte(8'h70);
        put_byte(8'h72);
        req = "R6";
        ev_last = 1; tick();
        wipe();
        // R7 TX sync ignores 0x72
        req = "R7";
        chan_kind = 2; rdy_set = 1; tick();
        ev_first = 1; tick();
        put_byte(8'h72);
        ev_last = 1; tick();
        wipe();
        // R8 RX control break and invalid command; single-quadlet buffer
        req = "R8";
        is_rx = 1; chan_kind = 0; rdy_set = 1; tick();
        ev_first = 1; byte_vld = 1; byte_val = 8'h22; tick();
        put_byte(8'h36);
        put_byte(8'h26);
        ev_last = 1; tick();
        rdy_set = 1; tick();
        ev_first = 1; ev_last = 1; byte_vld = 1; byte_val = 8'h99; tick();
        wipe();
        // R9 packet tracking on async
        req = "R9";
        chan_kind = 1; rdy_set = 1; tick();
        ev_first = 1; tick();
        put_byte(8'h20);
        put_byte(8'h22);
        put_byte(8'h24);
        put_byte(8'h20);
        ev_last = 1; tick();
        wipe();
        rdy_set = 1; tick();
        ev_first = 1; tick();
        put_byte(8'h20);
        ev_last = 1; tick();
        wipe();
        // R3 circular keeps ready, status to previous group
        req = "R3";
        ping_pong = 0; rdy_set = 1; tick();
        ev_first = 1; tick();
        tick();
        ev_last = 1; tick();
        ev_first = 1; tick();
        ev_last = 1; tick();
        rdy_clr = 1; tick();
        // R10 lost sync only on synchronous
        req = "R10";
        lost_sync_ev = 1; tick();
        chan_kind = 2; lost_sync_ev = 1; tick();
        // R11 bus fault with all enables low
        req = "R11";
        irq_en = 0; bus_fault_ev = 1; tick();
        // R12 set beats clear
        req = "R12";
        bus_fault_ev = 1; w1c_hbe = 1; lost_sync_ev = 1; w1c_lfs = 1; tick();
        w1c_hbe = 1; tick();
        // R13 enables per group
        req = "R13";
        irq_en = 9'h100; tick();
        w1c_lfs = 1; tick();
        ping_pong = 1; chan_kind = 1; rdy_set = 1; tick();
        ev_first = 1; tick();
        ev_last = 1; tick();
        irq_en = 9'h00F; tick();
        irq_en = 9'h0F0; tick();
        irq_en = 9'h020; tick();
        w1c_cur = 4'h2; tick();
        wipe();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule